// File: doc/BRIEF.md
# Unlock-Protected EEPROM Access Controller

This block gives a processor indirect access to a 256-byte, byte-addressed data EEPROM through four bus-visible registers: an address register, a data register, a control register and a key register. The key register cannot be read back. A read is started by setting a bit in the control register. The addressed byte appears in the data register one cycle later and stays there until the next read or until software overwrites it.

Writes are guarded. Write-enable must already be set. The key register must receive 0x55 and then 0xAA, and the very next bus access must set the write-start bit. Every byte needs a fresh key pair. A started write erases the location at once to 0xFF and stores the new byte after a fixed, parameterised number of cycles. When the write ends, the write-start bit drops and a sticky completion flag is raised.

There are two resets. A power-up reset clears everything, including write-enable, and starts a power-up timer that blocks writes until it expires. A warm reset aborts a write in progress and records the abort in an error bit.

Top module: `eectl_top`

## Requirements
- R1: After power-up reset, the address, data and control registers all read 0x00.
- R2: Register select 0 is the address, 1 the data, 2 the control and 3 the key register. Writing control bit 0 (read-start) as 1 makes bit 0 read 1 for exactly one cycle. In the following cycle the data register receives the byte at the current address.
- R3: Control bit 2 is write-enable and bit 1 is write-start. With write-enable already 1, a write of 0x55 to the key register, then 0xAA, then a control write with bit 1 set starts a write. Bit 1 then stays 1 for WR_CYCLES cycles. It clears when the byte is stored, at which point control bit 4 (write-done) and `doneIrq` become 1.
- R4: At the start of a write, the addressed location is erased to 0xFF. A read of that location while the write is still running returns 0xFF.
- R5: Any access that breaks the key sequence stops the write from starting and leaves the location unchanged. Such an access is a wrong key value, the two keys in reverse order, or any read or write between the steps.
- R6: Write-start cannot be set while write-enable is 0. The gate uses the write-enable value held before the control access.
- R7: Writing 0 to bit 1 or bit 2 while a write runs does not stop it; the new byte is still stored.
- R8: Write-done stays 1 until software writes the control register with bit 4 at 0; writing bit 4 as 1 leaves it alone. Hardware never clears write-enable, neither on completion nor on a warm reset.
- R9: A warm reset during a write clears write-start and sets control bit 3 (write-error). Software clears write-error by writing the control register with bit 3 at 0.
- R10: Reading the key register always returns 0x00.
- R11: For PU_CYCLES cycles after power-up reset, no write can start, even after a complete key sequence.
- R12: The key sequence is good for one byte only. A second control write with write-start set, without a new key pair, starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-up reset, asynchronous, active low |
| rstN | input | 1 | Warm reset, synchronous, active low |
| regSel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| wrStb | input | 1 | Bus write strobe |
| rdStb | input | 1 | Bus read strobe (counts as an access for the key sequence) |
| wdata | input | DATA_W | Bus write data |
| rdata | output | DATA_W | Contents of the selected register |
| doneIrq | output | 1 | Write-complete flag |

## Verification
The hardest case to reach from the ports is a warm reset that lands while a write is in flight. The bench runs a full key sequence so the write starts, and holds off for a couple of cycles. It then pulses the warm reset before the write timer has run out. The bench checks that write-error is set, that write-start has dropped and that write-enable survives. It also runs reads during a write, to see the erased value, and a set of deliberately broken key sequences, each followed by a read-back of the target byte.

// File: rtl/eectl_pkg.sv
package eectl_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_KEY  = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    K_IDLE  = 2'd0,
    K_HALF  = 2'd1,
    K_ARMED = 2'd2
  } keyState_e;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int BIT_RD    = 0;
  localparam int BIT_WR    = 1;
  localparam int BIT_ALLOW = 2;
  localparam int BIT_ERR   = 3;
  localparam int BIT_DONE  = 4;
  localparam int CTRL_BITS = 5;

  typedef struct packed {
    logic loadRead;
    logic startWrite;
    logic commitWrite;
  } strobe_t;
endpackage

// File: rtl/eectl_unlock.sv
module eectl_unlock
  import eectl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed
);
  keyState_e keyState;
  logic keyWr;
  logic [7:0] keyVal;

  assign keyWr  = wrStb && (regSel == SEL_KEY);
  assign keyVal = wdata[7:0];
  assign armed  = (keyState == K_ARMED);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      keyState <= K_IDLE;
    end else if (!rstN) begin
      keyState <= K_IDLE;
    end else if (keyWr) begin
      case (keyState)
        K_IDLE:  keyState <= (keyVal == KEY_FIRST)  ? K_HALF  : K_IDLE;
        K_HALF:  keyState <= (keyVal == KEY_SECOND) ? K_ARMED : K_IDLE;
        default: keyState <= K_IDLE;
      endcase
    end else if (wrStb || rdStb) begin
      keyState <= K_IDLE;
    end
  end
endmodule

// File: rtl/eectl_ctrl.sv
module eectl_ctrl
  import eectl_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 64,
  parameter int PU_CYCLES = 256
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 rstN,
  input  logic [1:0]           regSel,
  input  logic                 wrStb,
  input  logic [CTRL_BITS-1:0] ctrlIn,
  input  logic                 armed,
  output strobe_t              strb,
  output logic [DATA_W-1:0]    ctrlView,
  output logic                 doneIrq
);
  localparam int TW = $clog2(WR_CYCLES + 1);
  localparam int PW = $clog2(PU_CYCLES + 1);

  logic          rdGo, wrGo, wrAllow, wrErr, doneFlag;
  logic [TW-1:0] timer;
  logic [PW-1:0] puCnt;
  logic          puDone, ctrlWr;

  assign ctrlWr = wrStb && (regSel == SEL_CTRL);
  assign puDone = (puCnt == PW'(PU_CYCLES));

  assign strb.loadRead    = rdGo;
  assign strb.startWrite  = ctrlWr && ctrlIn[BIT_WR] && armed && wrAllow && !wrGo && puDone;
  assign strb.commitWrite = wrGo && (timer == '0);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rdGo     <= 1'b0;
      wrGo     <= 1'b0;
      wrAllow  <= 1'b0;
      wrErr    <= 1'b0;
      doneFlag <= 1'b0;
      timer    <= '0;
      puCnt    <= '0;
    end else begin
      if (!puDone) puCnt <= puCnt + 1'b1;
      if (!rstN) begin
        wrErr <= wrErr | wrGo;
        wrGo  <= 1'b0;
        rdGo  <= 1'b0;
        timer <= '0;
      end else begin
        rdGo <= ctrlWr && ctrlIn[BIT_RD];
        if (ctrlWr) begin
          wrAllow <= ctrlIn[BIT_ALLOW];
          if (!ctrlIn[BIT_ERR])  wrErr    <= 1'b0;
          if (!ctrlIn[BIT_DONE]) doneFlag <= 1'b0;
        end
        if (strb.startWrite) begin
          wrGo  <= 1'b1;
          timer <= TW'(WR_CYCLES - 1);
        end else if (strb.commitWrite) begin
          wrGo     <= 1'b0;
          doneFlag <= 1'b1;
        end else if (wrGo) begin
          timer <= timer - 1'b1;
        end
      end
    end
  end

  assign ctrlView = DATA_W'({doneFlag, wrErr, wrAllow, wrGo, rdGo});
  assign doneIrq  = doneFlag;
endmodule

// File: rtl/eectl_dp.sv
module eectl_dp
  import eectl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wdata,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] ctrlView,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrReg, wAddr;
  logic [DATA_W-1:0] dataReg, wData;

  always_ff @(posedge clk) begin
    if (strb.startWrite)       mem[addrReg] <= '1;
    else if (strb.commitWrite) mem[wAddr]   <= wData;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      addrReg <= '0;
      dataReg <= '0;
      wAddr   <= '0;
      wData   <= '0;
    end else if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (wrStb && regSel == SEL_ADDR) addrReg <= wdata[ADDR_W-1:0];
      if (strb.loadRead)                    dataReg <= mem[addrReg];
      else if (wrStb && regSel == SEL_DATA) dataReg <= wdata;
      if (strb.startWrite) begin
        wAddr <= addrReg;
        wData <= dataReg;
      end
    end
  end

  always_comb begin
    case (regSel)
      SEL_ADDR: rdata = DATA_W'(addrReg);
      SEL_DATA: rdata = dataReg;
      SEL_CTRL: rdata = ctrlView;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/eectl_top.sv
module eectl_top
  import eectl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 64,
  parameter int PU_CYCLES = 256
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              doneIrq
);
  strobe_t           strb;
  logic [DATA_W-1:0] ctrlView;
  logic              armed;

  eectl_unlock #(.DATA_W(DATA_W)) unlock_i (
    .clk(clk), .porN(porN), .rstN(rstN), .regSel(regSel),
    .wrStb(wrStb), .rdStb(rdStb), .wdata(wdata), .armed(armed)
  );

  eectl_ctrl #(.DATA_W(DATA_W), .WR_CYCLES(WR_CYCLES), .PU_CYCLES(PU_CYCLES)) ctrl_i (
    .clk(clk), .porN(porN), .rstN(rstN), .regSel(regSel), .wrStb(wrStb),
    .ctrlIn(wdata[CTRL_BITS-1:0]), .armed(armed), .strb(strb),
    .ctrlView(ctrlView), .doneIrq(doneIrq)
  );

  eectl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .porN(porN), .rstN(rstN), .regSel(regSel), .wrStb(wrStb),
    .wdata(wdata), .strb(strb), .ctrlView(ctrlView), .rdata(rdata)
  );
endmodule

// File: rtl/eectl_top_chk.sv
module eectl_top_chk
  import eectl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              porN,
  input logic              rstN,
  input logic [1:0]        regSel,
  input logic              wrStb,
  input logic              rdBit,
  input logic              doneBit,
  input logic [DATA_W-1:0] rdata,
  input logic              doneIrq,
  input logic [4:0]        ctrlBits,
  input strobe_t           strb
);
  logic ctrlWr;
  assign ctrlWr = wrStb && (regSel == 2'd2);

  // R2
  p_read_go_r2: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (ctrlWr && rdBit) |=> (ctrlBits[0] && strb.loadRead));
  p_read_once_r2: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (ctrlBits[0] && !(ctrlWr && rdBit)) |=> !ctrlBits[0]);
  // R3
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!porN || !rstN)
    strb.startWrite |=> ctrlBits[1]);
  p_done_on_end_r3: assert property (@(posedge clk) disable iff (!porN || !rstN)
    ($fell(ctrlBits[1]) && $past(rstN)) |-> doneIrq);
  // R6
  p_start_needs_allow_r6: assert property (@(posedge clk) disable iff (!porN || !rstN)
    $rose(ctrlBits[1]) |-> $past(ctrlBits[2]));
  // R7
  p_write_holds_r7: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (ctrlBits[1] && !strb.commitWrite) |=> ctrlBits[1]);
  // R8
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (doneIrq && !(ctrlWr && !doneBit)) |=> doneIrq);
  p_allow_kept_r8: assert property (@(posedge clk) disable iff (!porN)
    (ctrlBits[2] && !(ctrlWr && rstN)) |=> ctrlBits[2]);
  // R9
  p_err_from_reset_r9: assert property (@(posedge clk) disable iff (!porN || !rstN)
    $rose(ctrlBits[3]) |-> !$past(rstN));
  // R10
  p_key_reads_zero_r10: assert property (@(posedge clk) disable iff (!porN)
    (regSel == 2'd3) |-> (rdata == '0));
endmodule

bind eectl_top eectl_top_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .porN(porN), .rstN(rstN), .regSel(regSel), .wrStb(wrStb),
  .rdBit(wdata[0]), .doneBit(wdata[4]), .rdata(rdata), .doneIrq(doneIrq),
  .ctrlBits(ctrlView[4:0]), .strb(strb)
);

// File: tb/eectl_top_tb_top.sv
module eectl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WR_T = 6;
  localparam int PU_T = 20;

  // ADDR in [15:8], DATA in [7:0]
  localparam logic [15:0] VEC [8] = '{16'h003C, 16'hFFC3, 16'h0100, 16'h80FF,
                                      16'h7F5A, 16'h10A5, 16'h0201, 16'hFE80};

  logic clk = 1'b0, porN = 1'b0, rstN = 1'b1;
  logic [1:0] regSel = 2'd0;
  logic wrStb = 1'b0, rdStb = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic doneIrq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eectl_top #(.WR_CYCLES(WR_T), .PU_CYCLES(PU_T)) dut_i (
    .clk(clk), .porN(porN), .rstN(rstN), .regSel(regSel), .wrStb(wrStb),
    .rdStb(rdStb), .wdata(wdata), .rdata(rdata), .doneIrq(doneIrq)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] sel, input logic [7:0] val);
    regSel = sel; wdata = val; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic busRd(input logic [1:0] sel);
    regSel = sel; rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [7:0] val);
    regSel = sel;
    #1;
    val = rdata;
  endtask

  task automatic startWr(input logic [7:0] a, input logic [7:0] d);
    busWr(2'd0, a); busWr(2'd1, d);
    busWr(2'd3, 8'h55); busWr(2'd3, 8'hAA);
    busWr(2'd2, 8'h1E);
  endtask

  task automatic readByte(input logic [7:0] a, output logic [7:0] d);
    logic [7:0] c;
    busWr(2'd0, a);
    busWr(2'd2, 8'h1D);
    peek(2'd2, c);
    chk(c[0] == 1'b1, "R2 read-start high", c, c | 8'h01);
    @(negedge clk);
    peek(2'd1, d);
    peek(2'd2, c);
    chk(c[0] == 1'b0, "R2 read-start cleared", c, c & 8'hFE);
  endtask

  task automatic waitIdle();
    logic [7:0] c;
    for (int i = 0; i < 40; i++) begin
      peek(2'd2, c);
      if (!c[1]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    @(negedge clk); @(negedge clk);
    porN = 1'b1;
    // R1 reset state, R10 key reads zero
    peek(2'd0, v); chk(v == 8'h00, "R1 addr", v, 8'h00);
    peek(2'd1, v); chk(v == 8'h00, "R1 data", v, 8'h00);
    peek(2'd2, v); chk(v == 8'h00, "R1 ctrl", v, 8'h00);
    peek(2'd3, v); chk(v == 8'h00, "R10 key", v, 8'h00);
    // R11 power-up timer blocks write
    busWr(2'd2, 8'h1C);
    busWr(2'd3, 8'h55); busWr(2'd3, 8'hAA); busWr(2'd2, 8'h1E);
    peek(2'd2, v); chk(v[1] == 1'b0, "R11 blocked early", v, v & 8'hFD);
    repeat (PU_T + 5) @(negedge clk);

    // Table walk: R3 writes then R2 read-back
    foreach (VEC[i]) begin
      startWr(VEC[i][15:8], VEC[i][7:0]);
      peek(2'd2, v); chk(v[1] == 1'b1, "R3 write started", v, v | 8'h02);
      repeat (WR_T - 1) @(negedge clk);
      peek(2'd2, v); chk(v[1] == 1'b1, "R3 still writing", v, v | 8'h02);
      @(negedge clk);
      peek(2'd2, v);
      chk(v[1] == 1'b0 && v[4] == 1'b1 && doneIrq, "R3 completion", v, 8'h14);
      chk(v[2] == 1'b1, "R8 enable kept", v, v | 8'h04);
      busWr(2'd2, 8'h0C);
    end
    foreach (VEC[i]) begin
      readByte(VEC[i][15:8], v);
      chk(v == VEC[i][7:0], "R2 read-back", v, VEC[i][7:0]);
    end

    // R4 erase visible, R7 write not aborted by zeros
    startWr(8'h40, 8'h77);
    busWr(2'd2, 8'h19);
    @(negedge clk);
    peek(2'd1, v); chk(v == 8'hFF, "R4 erased during write", v, 8'hFF);
    peek(2'd2, v); chk(v[1] == 1'b1, "R7 write-start kept", v, v | 8'h02);
    chk(v[2] == 1'b0, "R7 enable cleared by software", v, v & 8'hFB);
    waitIdle();
    peek(2'd2, v); chk(v[4] == 1'b1, "R8 done set", v, v | 8'h10);
    busWr(2'd2, 8'h1C);
    readByte(8'h40, v); chk(v == 8'h77, "R7 byte stored", v, 8'h77);
    // R8 done sticky, R12 one byte per key pair
    peek(2'd2, v); chk(v[4] == 1'b1 && doneIrq, "R8 done held", v, v | 8'h10);
    busWr(2'd2, 8'h1E);
    peek(2'd2, v); chk(v[1] == 1'b0, "R12 no rekey no write", v, v & 8'hFD);
    busWr(2'd2, 8'h0C);
    chk(!doneIrq, "R8 done cleared", {7'd0, doneIrq}, 8'h00);

    // R5 broken sequences
    startWr(8'h50, 8'h11); waitIdle();
    busWr(2'd1, 8'hEE);
    busWr(2'd3, 8'hAA); busWr(2'd3, 8'h55); busWr(2'd2, 8'h1E);
    peek(2'd2, v); chk(v[1] == 1'b0, "R5 reversed keys", v, v & 8'hFD);
    busWr(2'd3, 8'h55); busRd(2'd1); busWr(2'd3, 8'hAA); busWr(2'd2, 8'h1E);
    peek(2'd2, v); chk(v[1] == 1'b0, "R5 read between keys", v, v & 8'hFD);
    busWr(2'd3, 8'h55); busWr(2'd3, 8'hAB); busWr(2'd2, 8'h1E);
    peek(2'd2, v); chk(v[1] == 1'b0, "R5 wrong key", v, v & 8'hFD);
    busWr(2'd3, 8'h55); busWr(2'd3, 8'hAA); busWr(2'd0, 8'h50); busWr(2'd2, 8'h1E);
    peek(2'd2, v); chk(v[1] == 1'b0, "R5 write before start", v, v & 8'hFD);
    // R6 enable gate uses held value
    busWr(2'd2, 8'h18);
    busWr(2'd3, 8'h55); busWr(2'd3, 8'hAA); busWr(2'd2, 8'h1E);
    peek(2'd2, v); chk(v[1] == 1'b0, "R6 no enable no write", v, v & 8'hFD);
    readByte(8'h50, v); chk(v == 8'h11, "R5 R6 location unchanged", v, 8'h11);
    // R10 key read after key write
    busWr(2'd3, 8'h55);
    peek(2'd3, v); chk(v == 8'h00, "R10 key after write", v, 8'h00);

    // R9 warm reset during write
    startWr(8'h60, 8'h33);
    @(negedge clk); @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    peek(2'd2, v);
    chk(v[3] == 1'b1 && v[1] == 1'b0, "R9 error after abort", v, (v | 8'h08) & 8'hFD);
    chk(v[2] == 1'b1, "R8 enable survives warm reset", v, v | 8'h04);
    busWr(2'd2, 8'h14);
    peek(2'd2, v); chk(v[3] == 1'b0, "R9 error cleared", v, v & 8'hF7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule